// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit status word of a small microcontroller core. It lives at data address 0x0A and is read by software through `stat_rdata`. The low four bits are the arithmetic flags: carry, half carry (carry between nibbles), zero and signed overflow. The ALU can update each of these on its own through a per-flag enable, and an ordinary bus write to the register's address can also load them.

Bits 4 and 5 are the sleep flag and the watchdog-expiry flag. Software cannot write them. They change only on four system events: power-up (the active-low reset), the watchdog-clear instruction, the halt instruction and a watchdog overflow. Bits 6 and 7 always read as zero. Saving and restoring the register around interrupts or calls is left to software.

The two guarded bits form a four-state machine:
- `GS_CLEAR`: neither bit set.
- `GS_ASLEEP`: the sleep bit only.
- `GS_TIMEOUT`: the expiry bit only.
- `GS_SLEEP_TIMEOUT`: both bits.

Each event moves the machine between these states.
- A halt enters `GS_ASLEEP`, or `GS_SLEEP_TIMEOUT` when an overflow arrives in the same cycle.
- A watchdog clear returns the machine to `GS_CLEAR`, unless an overflow or a halt in the same cycle overrides it.
- An overflow sets the expiry bit from any state. It moves `GS_CLEAR` to `GS_TIMEOUT` and `GS_ASLEEP` to `GS_SLEEP_TIMEOUT`.
- With no event, the machine holds its state.

Top module: `stat_flags_reg`

## Requirements
- R1: A bus write with `bus_wr_en` high and `bus_addr` equal to 0x0A, when no ALU enable is active, loads `sw_wdata[3:0]` into bits 3:0 of the register. The new value is visible on `stat_rdata` after the next rising clock edge.
- R2: A bus write to any address other than 0x0A leaves all bits of `stat_rdata` unchanged.
- R3: The read layout is fixed as follows: carry at bit 0, half carry at bit 1, zero at bit 2, overflow at bit 3, sleep at bit 4 and watchdog expiry at bit 5. Bits 7:6 always read 0.
- R4: A bus write never changes bits 5:4.
- R5: When `alu_we[i]` is high, flag bit i takes `alu_val[i]` at the next edge. Flags whose enable is low keep their value when there is no bus write.
- R6: When an ALU update and a bus write hit the register in the same cycle, each ALU-enabled flag takes `alu_val[i]` and each other flag takes `sw_wdata[i]`.
- R7: While `rst_n` is low, `stat_rdata` reads 0x00. This models power-up.
- R8: A `halt_evt` pulse sets bit 4 and clears bit 5, unless `wdt_ovf_evt` is high in the same cycle.
- R9: A `clr_wdt_evt` pulse alone clears bits 4 and 5.
- R10: A `wdt_ovf_evt` pulse sets bit 5 even if a clear or a halt arrives in the same cycle. It does not change bit 4 by itself.
- R11: When `halt_evt` and `clr_wdt_evt` arrive together, bit 4 ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| bus_wr_en | input | 1 | Data-memory write strobe |
| bus_addr | input | 8 | Data-memory write address |
| sw_wdata | input | 4 | Write data for the arithmetic flags (low nibble of the data bus) |
| alu_we | input | 4 | Per-flag ALU update enables, in bit order C, AC, Z, OV |
| alu_val | input | 4 | ALU flag results, same order as `alu_we` |
| clr_wdt_evt | input | 1 | One-cycle pulse: watchdog-clear instruction executed |
| halt_evt | input | 1 | One-cycle pulse: halt instruction executed |
| wdt_ovf_evt | input | 1 | One-cycle pulse: watchdog counter overflowed |
| stat_rdata | output | 8 | Register read value |

## Verification
The hardest situations to reach are event coincidences that start from a state already holding both guarded bits. For example, a clear, a halt and an overflow can all arrive while the sleep and expiry bits are both set. The bench therefore drives each of the four guarded states from the ports: it clears first, then halts, then lets the watchdog overflow, in that order, because a halt would wipe the expiry bit. From each state it applies all eight event combinations and then tries a full software write over the guarded bits. Per-flag precedence between the ALU and the bus is swept over all sixteen enable masks with conflicting data.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int FLAG_W   = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;

    localparam int BIT_PD   = 4;
    localparam int BIT_TO   = 5;

    // State encoding: bit 0 = sleep flag, bit 1 = watchdog expiry flag.
    typedef enum logic [1:0] {
        GS_CLEAR         = 2'b00,
        GS_ASLEEP        = 2'b01,
        GS_TIMEOUT       = 2'b10,
        GS_SLEEP_TIMEOUT = 2'b11
    } guard_state_e;

    function automatic guard_state_e gs_pick(input logic pd, input logic to);
        return guard_state_e'({to, pd});
    endfunction

endpackage

// File: rtl/stat_arith_flags.sv
module stat_arith_flags #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] alu_we,
    input  logic [FLAG_W-1:0] alu_val,
    output logic [FLAG_W-1:0] flags_q
);

    // Each flag has its own update path; the ALU result outranks the bus write.
    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
        logic nxt;

        always_comb begin
            if (alu_we[gi]) begin
                nxt = alu_val[gi];
            end else if (wr_hit) begin
                nxt = wr_data[gi];
            end else begin
                nxt = flags_q[gi];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[gi] <= 1'b0;
            end else begin
                flags_q[gi] <= nxt;
            end
        end
    end

endmodule

// File: rtl/stat_guard_fsm.sv
module stat_guard_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_evt,
    input  logic halt_evt,
    input  logic ovf_evt,
    output logic pd_o,
    output logic to_o
);

    guard_state_e state_q, state_d;

    // Keep-conditions: the sleep bit survives unless cleared, the expiry bit
    // survives unless cleared or halted; set terms override both.
    logic pd_keep, to_keep;
    assign pd_keep = halt_evt | ~clr_evt;
    assign to_keep = ovf_evt | (~clr_evt & ~halt_evt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_CLEAR:         state_d = gs_pick(halt_evt, ovf_evt);
            GS_ASLEEP:        state_d = gs_pick(pd_keep,  ovf_evt);
            GS_TIMEOUT:       state_d = gs_pick(halt_evt, to_keep);
            GS_SLEEP_TIMEOUT: state_d = gs_pick(pd_keep,  to_keep);
            default:          state_d = GS_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pd_o = 1'b0;
        to_o = 1'b0;
        unique case (state_q)
            GS_CLEAR:         begin pd_o = 1'b0; to_o = 1'b0; end
            GS_ASLEEP:        begin pd_o = 1'b1; to_o = 1'b0; end
            GS_TIMEOUT:       begin pd_o = 1'b0; to_o = 1'b1; end
            GS_SLEEP_TIMEOUT: begin pd_o = 1'b1; to_o = 1'b1; end
            default:          begin pd_o = 1'b0; to_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/stat_flags_reg.sv
module stat_flags_reg
    import stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FLAG_W-1:0] sw_wdata,
    input  logic [FLAG_W-1:0] alu_we,
    input  logic [FLAG_W-1:0] alu_val,
    input  logic              clr_wdt_evt,
    input  logic              halt_evt,
    input  logic              wdt_ovf_evt,
    output logic [DATA_W-1:0] stat_rdata
);

    localparam int PAD_W = DATA_W - BIT_TO - 1;

    logic              wr_hit;
    logic [FLAG_W-1:0] arith_q;
    logic              pd_q, to_q;

    assign wr_hit = bus_wr_en && (bus_addr == STAT_ADDR);

    stat_arith_flags #(.FLAG_W(FLAG_W)) u_arith (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (sw_wdata),
        .alu_we  (alu_we),
        .alu_val (alu_val),
        .flags_q (arith_q)
    );

    stat_guard_fsm u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_evt  (clr_wdt_evt),
        .halt_evt (halt_evt),
        .ovf_evt  (wdt_ovf_evt),
        .pd_o     (pd_q),
        .to_o     (to_q)
    );

    assign stat_rdata = {{PAD_W{1'b0}}, to_q, pd_q, arith_q};

endmodule

// File: rtl/stat_flags_chk.sv
module stat_flags_chk
    import stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FLAG_W-1:0] sw_wdata,
    input logic [FLAG_W-1:0] alu_we,
    input logic [FLAG_W-1:0] alu_val,
    input logic              clr_wdt_evt,
    input logic              halt_evt,
    input logic              wdt_ovf_evt,
    input logic [DATA_W-1:0] stat_rdata
);

    logic no_evt;
    assign no_evt = !clr_wdt_evt && !halt_evt && !wdt_ovf_evt;

    assert_sw_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == STAT_ADDR && alu_we == '0)
        |=> stat_rdata[FLAG_W-1:0] == $past(sw_wdata));

    assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr != STAT_ADDR && alu_we == '0 && no_evt)
        |=> $stable(stat_rdata));

    assert_pad_zero_R3: assert property (@(posedge clk)
        stat_rdata[DATA_W-1:BIT_TO+1] == '0);

    assert_guard_protected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && no_evt) |=> $stable(stat_rdata[BIT_TO:BIT_PD]));

    assert_alu_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we != '0)
        |=> ((stat_rdata[FLAG_W-1:0] & $past(alu_we)) == ($past(alu_val) & $past(alu_we))));

    assert_powerup_R7: assert property (@(posedge clk)
        !rst_n |-> stat_rdata == '0);

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_evt && !wdt_ovf_evt) |=> stat_rdata[BIT_TO:BIT_PD] == 2'b01);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt_evt && !halt_evt && !wdt_ovf_evt) |=> stat_rdata[BIT_TO:BIT_PD] == 2'b00);

    assert_ovf_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_evt |=> stat_rdata[BIT_TO]);

    assert_halt_over_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_evt && clr_wdt_evt) |=> stat_rdata[BIT_PD]);

endmodule

bind stat_flags_reg stat_flags_chk #(.STAT_ADDR(STAT_ADDR)) u_chk (.*);

// File: tb/stat_flags_reg_tb.sv
module stat_flags_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [3:0] sw_wdata = 4'h0;
    logic [3:0] alu_we = 4'h0;
    logic [3:0] alu_val = 4'h0;
    logic       clr_wdt_evt = 1'b0;
    logic       halt_evt = 1'b0;
    logic       wdt_ovf_evt = 1'b0;
    logic [7:0] stat_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;

    logic [3:0] m_flags = 4'h0;
    logic       m_pd = 1'b0;
    logic       m_to = 1'b0;

    always #5 clk = ~clk;

    stat_flags_reg u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_en   (bus_wr_en),
        .bus_addr    (bus_addr),
        .sw_wdata    (sw_wdata),
        .alu_we      (alu_we),
        .alu_val     (alu_val),
        .clr_wdt_evt (clr_wdt_evt),
        .halt_evt    (halt_evt),
        .wdt_ovf_evt (wdt_ovf_evt),
        .stat_rdata  (stat_rdata)
    );

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", n_cycles);
            report_end();
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, stat_rdata, {2'b00, m_to, m_pd, m_flags});
    endtask

    // One cycle of stimulus; the model follows the requirements R1..R11.
    task automatic drive(input logic wr, input logic [7:0] addr, input logic [3:0] wd,
                         input logic [3:0] we, input logic [3:0] av,
                         input logic clr, input logic hlt, input logic ovf);
        @(negedge clk);
        bus_wr_en = wr; bus_addr = addr; sw_wdata = wd;
        alu_we = we; alu_val = av;
        clr_wdt_evt = clr; halt_evt = hlt; wdt_ovf_evt = ovf;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0; alu_we = 4'h0; clr_wdt_evt = 1'b0; halt_evt = 1'b0; wdt_ovf_evt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (we[i]) m_flags[i] = av[i];
            else if (wr && addr == 8'h0A) m_flags[i] = wd[i];
        end
        if (hlt) m_pd = 1'b1;
        else if (clr) m_pd = 1'b0;
        if (ovf) m_to = 1'b1;
        else if (clr || hlt) m_to = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_flags = 4'h0; m_pd = 1'b0; m_to = 1'b0;
        #1;
        check_all("R7 (reset asserted)");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R7 (after release)");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();

        // R1 and R3: every nibble written at the register address
        for (int v = 0; v < 16; v++) begin
            drive(1'b1, 8'h0A, v[3:0], 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
            check_all("R1/R3");
        end

        // R5 and R6: every enable mask, conflicting bus and ALU data
        for (int we = 0; we < 16; we++) begin
            for (int k = 0; k < 4; k++) begin
                logic [3:0] av;
                av = (k == 0) ? 4'h0 : (k == 1) ? 4'hF : (k == 2) ? 4'h5 : 4'hA;
                drive(1'b1, 8'h0A, ~av, we[3:0], av, 1'b0, 1'b0, 1'b0);
                check_all(we == 0 ? "R1" : "R6");
                drive(1'b0, 8'h0A, av, we[3:0], ~av, 1'b0, 1'b0, 1'b0);
                check_all("R5");
            end
        end

        // R2: every other address
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h0A) begin
                drive(1'b1, a[7:0], ~m_flags, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
                check_all("R2");
            end
        end

        // R4, R8..R11: all event combinations from all guarded states
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 8; e++) begin
                drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
                if (s[0]) drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
                if (s[1]) drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
                check_all("R8/R10 (setup)");
                drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, e[0], e[1], e[2]);
                if (e[2])             check_all("R10");
                else if (e[1] && e[0]) check_all("R11");
                else if (e[1])        check_all("R8");
                else if (e[0])        check_all("R9");
                else                  check_all("R4 (idle hold)");
                drive(1'b1, 8'h0A, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
                check_all("R4");
                drive(1'b1, 8'h0A, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
                check_all("R4");
            end
        end

        // R7 mid-run: all bits set, then power-up
        drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
        drive(1'b0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
        drive(1'b1, 8'h0A, 4'hF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        check_all("R7 (preload)");
        do_reset();

        report_end();
    end

endmodule